// File: doc/BRIEF.md
# Variable-Divider Dot Clock Generator

This block turns a fast master clock into two single-cycle enable strobes for a video pipeline: a serial enable, which marks each serial (half-pixel) period, and a pixel enable, which marks every second serial enable. Downstream logic advances on these strobes and never uses a derived clock.

In narrow mode every serial period is five master clocks long. In wide mode most serial periods are four master clocks long. During the horizontal sync interval and the first pixel after it, a fixed mix of five-clock and four-clock periods is used instead, so a wide line of 840 serial periods takes exactly as many master clocks as a narrow line of 684 periods: 3420.

The generator keeps its own serial index inside the line and wraps it at the line length for the current mode. The horizontal counter pulses `sync_start` at the start of sync. This puts the index back to zero and restarts the current period.

Top module: `dot_clock_gen`

## Requirements
- R1: While `rst` is high both enables stay low. The first `ser_en` is high in the fifth master cycle after the last clock edge at which `rst` was sampled high.
- R2: In narrow mode (`wide_mode` = 0) each serial period lasts 5 master clocks.
- R3: `pix_en` is high only together with `ser_en`, and only on the pulse that ends an odd serial index. Indices 0 and 1 form the first pixel, so from index 0 `pix_en` falls on every second `ser_en`.
- R4: In wide mode (`wide_mode` = 1), serial indices 0 to 63 after the sync marker run in this order: 15 periods of 5 clocks, 2 of 4, 15 of 5, 2 of 4, 15 of 5, 2 of 4, then 13 of 5. The 64 periods total 314 master clocks.
- R5: In wide mode, indices 64 and 65 last 5 master clocks each. Every index from 66 to 839 lasts 4 master clocks.
- R6: With no marker, the index wraps to 0 after the last index of the line (683 narrow, 839 wide) and the schedule repeats. A full line is 3420 master clocks in either mode.
- R7: A `sync_start` pulse sampled at an edge starts index 0 with its phase at zero, so the next `ser_en` comes 5 cycles later. A `ser_en` already due in the marker's cycle is still issued.
- R8: Each `ser_en` and `pix_en` pulse lasts exactly one master cycle.
- R9: The divisor of a serial period is fixed by the mode sampled at the edge that starts the period. A mode change in the middle of a period only takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0 selects narrow (fixed divide), 1 selects wide (scheduled divide) |
| sync_start | input | 1 | One-cycle marker from the horizontal counter at the start of sync |
| ser_en | output | 1 | Serial-period enable, one master cycle wide |
| pix_en | output | 1 | Pixel enable, on every second serial enable |

## Verification
A marker or reset sampled at an edge produces a `ser_en` in the fifth following cycle. `pix_en` is due in the same cycle as the `ser_en` that ends an odd index. A mode change only shows in the period after the next pulse.

The bench reference model rebuilds the period length at every period start from the index and the mode it saw at that edge, then counts master cycles. Outputs are compared on the falling edge of every clock, away from the active edge. Gap measurements start on the falling edge where the marker is driven or where a pulse is seen, so they count the same cycles as the definition above.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } dclk_mode_e;

    // Default line geometry and divide schedule
    localparam int unsigned DEF_NARROW_DIV     = 5;
    localparam int unsigned DEF_FAST_DIV       = 4;
    localparam int unsigned DEF_SLOW_DIV       = 5;
    localparam int unsigned DEF_NARROW_SERIALS = 684;
    localparam int unsigned DEF_WIDE_SERIALS   = 840;
    localparam int unsigned DEF_SLOW_RUN       = 15;
    localparam int unsigned DEF_FAST_RUN       = 2;
    localparam int unsigned DEF_LAST_RUN       = 13;
    localparam int unsigned DEF_BURSTS         = 3;
    localparam int unsigned DEF_PORCH_SLOW     = 2;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dclk_div_sched.sv
module dclk_div_sched
    import dclk_pkg::*;
#(
    parameter int unsigned NARROW_DIV = DEF_NARROW_DIV,
    parameter int unsigned FAST_DIV   = DEF_FAST_DIV,
    parameter int unsigned SLOW_DIV   = DEF_SLOW_DIV,
    parameter int unsigned SLOW_RUN   = DEF_SLOW_RUN,
    parameter int unsigned FAST_RUN   = DEF_FAST_RUN,
    parameter int unsigned LAST_RUN   = DEF_LAST_RUN,
    parameter int unsigned BURSTS     = DEF_BURSTS,
    parameter int unsigned PORCH_SLOW = DEF_PORCH_SLOW,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned DIV_W      = 3
) (
    input  dclk_mode_e       mode_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [DIV_W-1:0] div_o
);
    localparam int unsigned BURST_LEN = SLOW_RUN + FAST_RUN;
    localparam int unsigned SYNC_END  = BURSTS * BURST_LEN + LAST_RUN;
    localparam int unsigned SLOW_END  = SYNC_END + PORCH_SLOW;

    logic [31:0] idx_wide;
    logic        use_slow;

    always_comb begin
        idx_wide = 32'(idx_i);
        use_slow = 1'b0;
        // Bursts of slow periods separated by short fast runs
        for (int unsigned b = 0; b < BURSTS; b++) begin
            if (idx_wide >= b * BURST_LEN && idx_wide < b * BURST_LEN + SLOW_RUN) begin
                use_slow = 1'b1;
            end
        end
        // Final slow run of sync plus the first pixel of the porch
        if (idx_wide >= BURSTS * BURST_LEN && idx_wide < SLOW_END) begin
            use_slow = 1'b1;
        end
    end

    always_comb begin
        if (mode_i == MODE_NARROW) begin
            div_o = DIV_W'(NARROW_DIV);
        end else if (use_slow) begin
            div_o = DIV_W'(SLOW_DIV);
        end else begin
            div_o = DIV_W'(FAST_DIV);
        end
    end

endmodule

// File: rtl/dclk_index_ctr.sv
module dclk_index_ctr
    import dclk_pkg::*;
#(
    parameter int unsigned NARROW_SERIALS = DEF_NARROW_SERIALS,
    parameter int unsigned WIDE_SERIALS   = DEF_WIDE_SERIALS,
    parameter int unsigned IDX_W          = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_start,
    input  logic             ser_en_i,
    input  dclk_mode_e       mode_i,
    output logic [IDX_W-1:0] idx_next_o,
    output logic             pix_en_o
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_last;
    logic             restart;

    assign restart  = rst | sync_start;
    assign idx_last = (mode_i == MODE_WIDE) ? IDX_W'(WIDE_SERIALS - 1)
                                            : IDX_W'(NARROW_SERIALS - 1);

    always_comb begin
        if (restart) begin
            idx_next_o = '0;
        end else if (idx_q >= idx_last) begin
            idx_next_o = '0;
        end else begin
            idx_next_o = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (restart || ser_en_i) begin
            idx_q <= idx_next_o;
        end
    end

    // A pixel ends with the second serial period of each pair
    assign pix_en_o = ser_en_i & idx_q[0];

endmodule

// File: rtl/dclk_phase_ctr.sv
module dclk_phase_ctr #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_start,
    input  logic [DIV_W-1:0] div_i,
    output logic             ser_en_o
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] div_q;
    logic             load;

    assign ser_en_o = (phase_q == div_q - DIV_W'(1));
    assign load     = rst | sync_start | ser_en_o;

    always_ff @(posedge clk) begin
        if (load) begin
            phase_q <= '0;
            div_q   <= div_i;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/dot_clock_gen.sv
module dot_clock_gen
    import dclk_pkg::*;
#(
    parameter int unsigned NARROW_DIV     = DEF_NARROW_DIV,
    parameter int unsigned FAST_DIV       = DEF_FAST_DIV,
    parameter int unsigned SLOW_DIV       = DEF_SLOW_DIV,
    parameter int unsigned NARROW_SERIALS = DEF_NARROW_SERIALS,
    parameter int unsigned WIDE_SERIALS   = DEF_WIDE_SERIALS,
    parameter int unsigned SLOW_RUN       = DEF_SLOW_RUN,
    parameter int unsigned FAST_RUN       = DEF_FAST_RUN,
    parameter int unsigned LAST_RUN       = DEF_LAST_RUN,
    parameter int unsigned BURSTS         = DEF_BURSTS,
    parameter int unsigned PORCH_SLOW     = DEF_PORCH_SLOW
) (
    input  logic clk,
    input  logic rst,
    input  logic wide_mode,
    input  logic sync_start,
    output logic ser_en,
    output logic pix_en
);
    localparam int unsigned MAX_DIV = imax(NARROW_DIV, imax(FAST_DIV, SLOW_DIV));
    localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
    localparam int unsigned MAX_SER = imax(NARROW_SERIALS, WIDE_SERIALS);
    localparam int unsigned IDX_W   = $clog2(MAX_SER);

    dclk_mode_e       mode;
    logic [IDX_W-1:0] idx_next;
    logic [DIV_W-1:0] next_div;

    assign mode = dclk_mode_e'(wide_mode);

    dclk_index_ctr #(
        .NARROW_SERIALS (NARROW_SERIALS),
        .WIDE_SERIALS   (WIDE_SERIALS),
        .IDX_W          (IDX_W)
    ) u_index (
        .clk        (clk),
        .rst        (rst),
        .sync_start (sync_start),
        .ser_en_i   (ser_en),
        .mode_i     (mode),
        .idx_next_o (idx_next),
        .pix_en_o   (pix_en)
    );

    dclk_div_sched #(
        .NARROW_DIV (NARROW_DIV),
        .FAST_DIV   (FAST_DIV),
        .SLOW_DIV   (SLOW_DIV),
        .SLOW_RUN   (SLOW_RUN),
        .FAST_RUN   (FAST_RUN),
        .LAST_RUN   (LAST_RUN),
        .BURSTS     (BURSTS),
        .PORCH_SLOW (PORCH_SLOW),
        .IDX_W      (IDX_W),
        .DIV_W      (DIV_W)
    ) u_sched (
        .mode_i (mode),
        .idx_i  (idx_next),
        .div_o  (next_div)
    );

    dclk_phase_ctr #(
        .DIV_W (DIV_W)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .sync_start (sync_start),
        .div_i      (next_div),
        .ser_en_o   (ser_en)
    );

endmodule

// File: rtl/dclk_checker.sv
module dclk_checker #(
    parameter int unsigned NARROW_DIV = 5,
    parameter int unsigned FAST_DIV   = 4,
    parameter int unsigned SLOW_DIV   = 5
) (
    input logic clk,
    input logic rst,
    input logic wide_mode,
    input logic sync_start,
    input logic ser_en,
    input logic pix_en
);
    logic [7:0] gap_q;
    logic       par_q;
    logic       wide_ld_q;
    logic       from_sync_q;
    logic       mixed_q;
    logic       load;

    assign load = rst | sync_start | ser_en;

    always_ff @(posedge clk) begin
        if (load) begin
            gap_q       <= '0;
            wide_ld_q   <= wide_mode;
            from_sync_q <= rst | sync_start;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
        if (rst || sync_start) begin
            par_q   <= 1'b0;
            mixed_q <= 1'b0;
        end else begin
            if (ser_en) begin
                par_q <= ~par_q;
            end
            if (ser_en && (wide_mode != wide_ld_q)) begin
                mixed_q <= 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !ser_en && !pix_en); // R1

    AST_NARROW_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ser_en && !wide_ld_q |-> gap_q == 8'(NARROW_DIV - 1)); // R2

    AST_PIX_IN_SER: assert property (@(posedge clk) disable iff (rst)
        pix_en |-> ser_en); // R3

    AST_PIX_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        ser_en && !mixed_q |-> pix_en == par_q); // R3

    AST_WIDE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ser_en && wide_ld_q |-> gap_q == 8'(FAST_DIV - 1) || gap_q == 8'(SLOW_DIV - 1)); // R5

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        ser_en && from_sync_q |-> gap_q == (wide_ld_q ? 8'(SLOW_DIV - 1) : 8'(NARROW_DIV - 1))); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ser_en |=> !ser_en); // R8

endmodule

bind dot_clock_gen dclk_checker #(
    .NARROW_DIV (NARROW_DIV),
    .FAST_DIV   (FAST_DIV),
    .SLOW_DIV   (SLOW_DIV)
) u_dclk_checker (
    .clk        (clk),
    .rst        (rst),
    .wide_mode  (wide_mode),
    .sync_start (sync_start),
    .ser_en     (ser_en),
    .pix_en     (pix_en)
);

// File: tb/dot_clock_gen_bench.sv
module dot_clock_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wide_mode = 1'b0;
    logic sync_start = 1'b0;
    logic ser_en;
    logic pix_en;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dot_clock_gen u_dot_clock_gen (
        .clk        (clk),
        .rst        (rst),
        .wide_mode  (wide_mode),
        .sync_start (sync_start),
        .ser_en     (ser_en),
        .pix_en     (pix_en)
    );

    // Wide-mode period length by serial index (R4, R5)
    function automatic int wide_div(input int k);
        if (k < 15) return 5;
        if (k < 17) return 4;
        if (k < 32) return 5;
        if (k < 34) return 4;
        if (k < 49) return 5;
        if (k < 51) return 4;
        if (k < 64) return 5;
        if (k < 66) return 5;
        return 4;
    endfunction

    // Behavioural reference: elapsed cycles against the length chosen at period start
    int    m_idx = 0;
    int    m_div = 5;
    int    m_e = 0;
    bit    m_ser = 1'b0;
    bit    m_pix = 1'b0;
    bit    m_wide_ld = 1'b0;
    bit    m_live = 1'b0;
    string m_tag = "R1";

    always @(posedge clk) begin
        if (rst || sync_start || m_ser) begin
            if (rst) begin
                m_idx = 0;
                m_tag = "R1";
            end else if (sync_start) begin
                m_idx = 0;
                m_tag = "R7";
            end else begin
                m_idx = (m_idx >= (wide_mode ? 839 : 683)) ? 0 : m_idx + 1;
                if (wide_mode != m_wide_ld) m_tag = "R9";
                else if (!wide_mode) m_tag = "R2";
                else m_tag = (m_idx < 64) ? "R4" : "R5";
            end
            m_wide_ld = wide_mode;
            m_div = wide_mode ? wide_div(m_idx) : 5;
            m_e = 1;
        end else begin
            m_e++;
        end
        m_ser  = (m_e == m_div);
        m_pix  = m_ser && (m_idx % 2 == 1);
        m_live = 1'b1;
    end

    bit prev_ser = 1'b0;
    int double_pulses = 0;

    always @(negedge clk) begin
        if (m_live && !done) begin
            compared++;
            if (ser_en !== m_ser) begin
                mismatched++;
                $display("FAIL %s ser_en at idx %0d: actual %0b expected %0b", m_tag, m_idx, ser_en, m_ser);
            end
            compared++;
            if (pix_en !== m_pix) begin
                mismatched++;
                $display("FAIL R3 pix_en at idx %0d: actual %0b expected %0b", m_idx, pix_en, m_pix);
            end
            if (ser_en && prev_ser) double_pulses++;
            prev_ser = ser_en;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // From a falling edge, count falling edges until ser_en is seen high
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ser_en);
    endtask

    // Drive a one-cycle marker, then count to the next ser_en
    task automatic do_sync(output int n);
        sync_start = 1'b1;
        @(negedge clk);
        sync_start = 1'b0;
        n = 1;
        while (!ser_en) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R6 watchdog: actual %0d cycles expected fewer", WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int n;
        int sum;
        int bad;
        int pixes;
        int gaps[$];

        // R1: quiet in reset, first pulse one full period after release
        repeat (3) @(negedge clk);
        check("R1", "ser_en in reset", int'(ser_en), 0);
        check("R1", "pix_en in reset", int'(pix_en), 0);
        rst = 1'b0;
        measure(n);
        check("R1", "cycles to first ser_en", n, 4);

        // R2: narrow free-running periods
        for (int i = 0; i < 10; i++) begin
            measure(n);
            check("R2", "narrow period", n, 5);
        end

        // R6, R3: narrow line from the marker
        do_sync(n);
        sum = n;
        pixes = int'(pix_en);
        for (int i = 1; i < 684; i++) begin
            measure(n);
            sum += n;
            pixes += int'(pix_en);
        end
        check("R6", "narrow line master clocks", sum, 3420);
        check("R3", "narrow line pixel enables", pixes, 342);

        // Wide line from the marker
        wide_mode = 1'b1;
        @(negedge clk);
        do_sync(n);
        gaps.delete();
        gaps.push_back(n);
        for (int i = 1; i < 840; i++) begin
            measure(n);
            gaps.push_back(n);
        end
        bad = 0;
        sum = 0;
        for (int k = 0; k < 64; k++) begin
            if (gaps[k] != wide_div(k)) bad++;
            sum += gaps[k];
        end
        check("R4", "sync run pattern mismatches", bad, 0);
        check("R4", "sync region master clocks", sum, 314);
        bad = 0;
        for (int k = 64; k < 840; k++) begin
            if (gaps[k] != wide_div(k)) bad++;
        end
        check("R5", "porch and active period mismatches", bad, 0);
        check("R5", "first porch pixel serial period", gaps[64] + gaps[65], 10);
        sum = 0;
        foreach (gaps[k]) sum += gaps[k];
        check("R6", "wide line master clocks", sum, 3420);

        // R6: free-running wrap repeats the sync pattern
        sum = 0;
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            measure(n);
            sum += n;
            if (n != wide_div(k)) bad++;
        end
        check("R6", "wrapped sync region master clocks", sum, 314);
        check("R6", "wrapped sync pattern mismatches", bad, 0);

        // R7: marker in the same cycle as a due pulse
        do_sync(n);
        check("R7", "gap after coincident marker", n, 5);
        check("R3", "pix_en on index 0 pulse", int'(pix_en), 0);
        measure(n);
        check("R3", "pix_en on index 1 pulse", int'(pix_en), 1);

        // R7: marker in the middle of a period
        repeat (2) @(negedge clk);
        do_sync(n);
        check("R7", "gap after mid-period marker", n, 5);

        // R9: mode change mid-period waits for the next period
        for (int i = 0; i < 200; i++) measure(n);
        @(negedge clk);
        wide_mode = 1'b0;
        measure(n);
        check("R9", "period started in wide mode", n + 1, 4);
        measure(n);
        check("R9", "first period in narrow mode", n, 5);

        // Wide to narrow switch beyond the narrow line length
        wide_mode = 1'b1;
        @(negedge clk);
        do_sync(n);
        for (int i = 0; i < 700; i++) measure(n);
        wide_mode = 1'b0;
        for (int i = 0; i < 20; i++) measure(n);

        check("R8", "multi-cycle ser_en pulses", double_pulses, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule